// File: doc/BRIEF.md
# Partial-Tile Edge Mask Selector

This block trims the columns of a tile face when only part of a tile holds useful data. Each face row carries sixteen datums. For every row that passes through, the block picks one of four programmable sixteen-bit lane masks. It then zeroes the datums whose mask bit is clear and reports which lanes survived.

The mask is chosen per row, not for the whole face. Four row-mapping registers, one per face, hold a two-bit code for each of the sixteen rows. The code names the mask that applies to that row, so different rows of one face can be clipped to different widths. A mode bit held beside the first mask turns masking on; while it is clear, every lane passes. All registers are loaded through a single-word write port. The result leaves through one register stage, and a valid flag travels with it.

Top module: `edge_mask_sel`

## Requirements
- R1: After reset, out_valid, out_keep and out_data are all zero. The masks reset to all ones, the mode bit to 0 and every row-mapping register to 0.
- R2: out_valid in a cycle equals in_valid of the previous cycle (one register stage of latency).
- R3: The mode bit is bit 16 of the register at write address 0. While it is 0, every lane of a sample is kept and passed unchanged, whatever the masks and maps hold.
- R4: The mapping register for face f is at write address 4+f. Row r uses its bits [2r+1:2r] as a code c, and code c selects the mask at write address c.
- R5: With masking on, mask bit i = 1 keeps lane i, which is in_data[16i+15:16i]: out_keep[i] = 1 and the datum passes. Mask bit i = 0 drives that lane of out_data to zero and clears out_keep[i].
- R6: A write to address 0..3 loads wr_data[15:0] as that mask. A write to address 4..7 loads all 32 bits of wr_data as that mapping register.
- R7: Some written bits have no effect on the output: bits [31:17] of address 0, which include the 9-bit field at [25:17], and bits [31:16] of addresses 1..3.
- R8: A register write is used by samples presented from the next cycle on. A sample presented in the same cycle as a write is masked with the old settings.
- R9: While out_valid is 0, out_keep and out_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0..3 lane masks, 4..7 row-mapping registers of faces 0..3 |
| wr_data | input | 32 | Write data |
| in_valid | input | 1 | Input sample valid |
| in_face | input | 2 | Face index of the sample |
| in_row | input | 4 | Row index within the face |
| in_data | input | 256 | Sixteen 16-bit datums, lane i at [16i+15:16i] |
| out_valid | output | 1 | Output sample valid |
| out_keep | output | 16 | Per-lane keep flags |
| out_data | output | 256 | Masked datums |

## Verification
A register write and a sample can arrive in the same cycle. The sample must then be masked with the settings from before the write. The bench provokes this by rewriting mask 0 and, in that same cycle, presenting a sample whose row maps to mask 0, with masking on. The scoreboard builds its expected value from its own copy of the registers before it applies the write. It then requires the next sample, which it sends in the following cycle, to show the new mask.

// File: rtl/emask_pkg.sv
package emask_pkg;
    parameter int unsigned LANES    = 16;
    parameter int unsigned ROWS     = 16;
    parameter int unsigned NSEL     = 4;
    parameter int unsigned FACE_W   = 2;
    parameter int unsigned WORD_W   = 32;
    parameter int unsigned MODE_BIT = 16;
    localparam int unsigned CODE_W  = $clog2(NSEL);
    localparam int unsigned ROW_W   = $clog2(ROWS);
    localparam int unsigned NMAP    = 1 << FACE_W;
    localparam int unsigned IDX_W   = (NSEL > NMAP) ? $clog2(NSEL) : FACE_W;
    localparam int unsigned ADDR_W  = IDX_W + 1;
    localparam int unsigned MAP_W   = ROWS * CODE_W;

    typedef struct packed {
        logic [NSEL-1:0][LANES-1:0] mask;
        logic                       mode;
        logic [NMAP-1:0][MAP_W-1:0] rmap;
    } cfg_t;
endpackage

// File: rtl/emask_cfg_regs.sv
module emask_cfg_regs
    import emask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;
    logic [IDX_W-1:0] idx;
    logic unused_hi;

    assign idx       = wr_addr[IDX_W-1:0];
    assign unused_hi = ^wr_data[WORD_W-1:MODE_BIT+1];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (!wr_addr[ADDR_W-1]) begin
                cfg_d.mask[idx] = wr_data[LANES-1:0];
                if (idx == '0) begin
                    cfg_d.mode = wr_data[MODE_BIT];
                end
            end else begin
                cfg_d.rmap[idx] = wr_data[MAP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mask <= '1;
            cfg_q.mode <= 1'b0;
            cfg_q.rmap <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/emask_lane_gate.sv
module emask_lane_gate
    import emask_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  cfg_t                  cfg,
    input  logic [FACE_W-1:0]     face,
    input  logic [ROW_W-1:0]      row,
    input  logic [LANES*DW-1:0]   data_i,
    output logic [LANES-1:0]      keep_o,
    output logic [LANES*DW-1:0]   data_o
);
    logic [MAP_W-1:0]  map_word;
    logic [CODE_W-1:0] code;

    assign map_word = cfg.rmap[face];
    assign code     = map_word[row*CODE_W +: CODE_W];
    assign keep_o   = cfg.mode ? cfg.mask[code] : {LANES{1'b1}};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data_o[i*DW +: DW] = keep_o[i] ? data_i[i*DW +: DW] : '0;
    end
endmodule

// File: rtl/edge_mask_sel.sv
module edge_mask_sel
    import emask_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                in_valid,
    input  logic [FACE_W-1:0]   in_face,
    input  logic [ROW_W-1:0]    in_row,
    input  logic [LANES*DW-1:0] in_data,
    output logic                out_valid,
    output logic [LANES-1:0]    out_keep,
    output logic [LANES*DW-1:0] out_data
);
    typedef struct packed {
        logic                valid;
        logic [LANES-1:0]    keep;
        logic [LANES*DW-1:0] data;
    } out_t;

    cfg_t                cfg_w;
    logic [LANES-1:0]    gate_keep;
    logic [LANES*DW-1:0] gate_data;
    out_t                out_d, out_q;

    emask_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg_w)
    );

    emask_lane_gate #(.DW(DW)) u_gate (
        .cfg    (cfg_w),
        .face   (in_face),
        .row    (in_row),
        .data_i (in_data),
        .keep_o (gate_keep),
        .data_o (gate_data)
    );

    always_comb begin
        out_d       = '0;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.keep = gate_keep;
            out_d.data = gate_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_keep  = out_q.keep;
    assign out_data  = out_q.data;
endmodule

// File: rtl/emask_chk.sv
module emask_chk
    import emask_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [LANES*DW-1:0] in_data,
    input logic                out_valid,
    input logic [LANES-1:0]    out_keep,
    input logic [LANES*DW-1:0] out_data,
    input logic                mode_i
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid))); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_keep == '0 && out_data == '0)); // R9

    AST_BYPASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && !$past(mode_i)) |-> (out_keep == '1)); // R3

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        AST_DROPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_keep[i]) |-> (out_data[i*DW +: DW] == '0)); // R5
        AST_KEPT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && out_valid && out_keep[i]) |-> (out_data[i*DW +: DW] == $past(in_data[i*DW +: DW]))); // R5
    end
endmodule

bind edge_mask_sel emask_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_keep  (out_keep),
    .out_data  (out_data),
    .mode_i    (cfg_w.mode)
);

// File: tb/test_edge_mask_sel.sv
module test_edge_mask_sel;
    localparam int DW = 16;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_face = '0;
    logic [3:0]    in_row = '0;
    logic [NL*DW-1:0] in_data = '0;
    logic          out_valid;
    logic [NL-1:0] out_keep;
    logic [NL*DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_mask [4];
    logic        m_mode;
    logic [31:0] m_map [4];

    logic [NL-1:0]    q_keep [$];
    logic [NL*DW-1:0] q_data [$];
    string            q_tag  [$];

    always #5ns clk = ~clk;

    edge_mask_sel #(.DW(DW)) i_edge_mask_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .in_valid(in_valid), .in_face(in_face),
        .in_row(in_row), .in_data(in_data), .out_valid(out_valid),
        .out_keep(out_keep), .out_data(out_data)
    );

    function automatic logic [NL*DW-1:0] pattern(input logic [1:0] f, input logic [3:0] r, input int salt);
        logic [NL*DW-1:0] v;
        for (int i = 0; i < NL; i++) begin
            v[i*DW +: DW] = 16'(16'h8000 + salt * 16'h0400 + f * 16'h0100 + r * 16'h0010 + i);
        end
        return v;
    endfunction

    // Drives one cycle; expectation uses the model before this cycle's write (R8)
    task automatic step(input bit w, input logic [2:0] a, input logic [31:0] d,
                        input bit v, input logic [1:0] f, input logic [3:0] r,
                        input int salt, input string tag);
        logic [NL*DW-1:0] dv;
        logic [NL-1:0]    k;
        logic [NL*DW-1:0] ed;
        logic [1:0]       code;
        @(negedge clk);
        dv = pattern(f, r, salt);
        if (v) begin
            code = m_map[f][2*r +: 2];
            k = m_mode ? m_mask[code] : 16'hFFFF;
            for (int i = 0; i < NL; i++) ed[i*DW +: DW] = k[i] ? dv[i*DW +: DW] : 16'h0;
            q_keep.push_back(k);
            q_data.push_back(ed);
            q_tag.push_back(tag);
        end
        if (w) begin
            if (!a[2]) begin
                m_mask[a[1:0]] = d[15:0];
                if (a[1:0] == 2'd0) m_mode = d[16];
            end else begin
                m_map[a[1:0]] = d;
            end
        end
        wr_en = w; wr_addr = a; wr_data = d;
        in_valid = v; in_face = f; in_row = r; in_data = dv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 3'd0, 32'h0, 0, 2'd0, 4'd0, 0, "");
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1, a, d, 0, 2'd0, 4'd0, 0, "");
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2ns;
            if (rst_n && !done) begin
                if (out_valid) begin
                    checks++;
                    if (q_keep.size() == 0) begin
                        errors++;
                        $display("FAIL R2: unexpected out_valid actual=1 expected=0");
                    end else begin
                        logic [NL-1:0] ek;
                        logic [NL*DW-1:0] ed;
                        string t;
                        ek = q_keep.pop_front();
                        ed = q_data.pop_front();
                        t  = q_tag.pop_front();
                        if (out_keep !== ek || out_data !== ed) begin
                            errors++;
                            $display("FAIL %s: keep actual=%h expected=%h data actual=%h expected=%h",
                                     t, out_keep, ek, out_data, ed);
                        end
                    end
                end else begin
                    checks++;
                    if (out_keep !== '0 || out_data !== '0) begin
                        errors++;
                        $display("FAIL R9: idle outputs actual keep=%h data=%h expected=0", out_keep, out_data);
                    end
                end
            end
        end
    end

    initial begin
        logic [31:0] mp;
        for (int i = 0; i < 4; i++) begin m_mask[i] = 16'hFFFF; m_map[i] = '0; end
        m_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1ns;
        checks++;
        if (out_valid !== 1'b0 || out_keep !== '0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: reset outputs actual v=%b keep=%h expected 0", out_valid, out_keep);
        end
        // R1/R3: reset config bypasses masking
        step(0, 3'd0, 32'h0, 1, 2'd0, 4'd0, 1, "R1");
        step(0, 3'd0, 32'h0, 1, 2'd3, 4'd15, 2, "R3");
        idle(1);
        // R5/R6: enable mode, mask 0 keeps lanes 0..7
        wr(3'd0, 32'h0001_00FF);
        wr(3'd1, 32'h0000_0F0F);
        wr(3'd2, 32'h0000_FFF0);
        wr(3'd3, 32'h0000_8001);
        step(0, 3'd0, 32'h0, 1, 2'd0, 4'd5, 3, "R5");
        step(0, 3'd0, 32'h0, 1, 2'd3, 4'd9, 4, "R6");
        // R4: face 1 code = row mod 4, face 2 code = 3 - row mod 4
        mp = '0;
        for (int r = 0; r < 16; r++) mp[2*r +: 2] = 2'(r % 4);
        wr(3'd5, mp);
        mp = '0;
        for (int r = 0; r < 16; r++) mp[2*r +: 2] = 2'(3 - (r % 4));
        wr(3'd6, mp);
        for (int r = 0; r < 16; r++) step(0, 3'd0, 32'h0, 1, 2'd1, 4'(r), 5, "R4");
        for (int r = 0; r < 16; r += 3) step(0, 3'd0, 32'h0, 1, 2'd2, 4'(r), 6, "R4");
        step(0, 3'd0, 32'h0, 1, 2'd0, 4'd2, 7, "R4");
        idle(2);
        // R8: write mask 0 with a sample in the same cycle, then one after
        step(1, 3'd0, 32'h0001_3C3C, 1, 2'd0, 4'd1, 8, "R8");
        step(0, 3'd0, 32'h0, 1, 2'd0, 4'd1, 9, "R8");
        // R8: remap face 1 while a row of it is presented
        step(1, 3'd5, 32'hFFFF_FFFF, 1, 2'd1, 4'd1, 10, "R8");
        step(0, 3'd0, 32'h0, 1, 2'd1, 4'd1, 11, "R8");
        idle(1);
        // R7: junk upper bits on mask writes have no effect
        wr(3'd0, 32'hABFF_00F0 | 32'h0001_0000);
        wr(3'd2, 32'hFFFF_0003);
        step(0, 3'd0, 32'h0, 1, 2'd0, 4'd0, 12, "R7");
        step(0, 3'd0, 32'h0, 1, 2'd2, 4'd1, 13, "R7");
        step(0, 3'd0, 32'h0, 1, 2'd1, 4'd4, 14, "R7");
        idle(1);
        // R3: mode off with nonzero maps bypasses
        wr(3'd0, 32'h0000_0000);
        step(0, 3'd0, 32'h0, 1, 2'd1, 4'd3, 15, "R3");
        step(0, 3'd0, 32'h0, 1, 2'd2, 4'd6, 16, "R3");
        // R2: gapped stream
        step(0, 3'd0, 32'h0, 1, 2'd0, 4'd7, 17, "R2");
        idle(1);
        step(0, 3'd0, 32'h0, 1, 2'd3, 4'd8, 18, "R2");
        idle(3);
        checks++;
        if (q_keep.size() != 0) begin
            errors++;
            $display("FAIL R2: pending results actual=%0d expected=0", q_keep.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2: watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule